// File: doc/BRIEF.md
# Framed PCM Receiver: Sync Search and Word Recovery

This block takes a serial PCM line, sampled by a local clock that runs several times faster than the bit rate. It locates the long high sync field that separates frames and restarts its bit timing when that field ends. It then recovers the four-bit data word carried in each frame and presents it on a parallel output that holds its value. A downstream converter can use that output directly.

A frame is two low guard bits, then four data bits sent most significant first, then two low guard bits, then the sync field. The sync field is a high run longer than any run that guard and data bits can form. The receiver takes one sample in the middle of each of the eight guard and data bits and then stops sampling. One further timing event, half a bit into the sync field, checks the guard bits and transfers the word. A lock flag reports whether good frames are still arriving.

Top module: `pcm_frame_rx`

## Requirements
- R1: The sync field is recognised only after the registered line has been high for at least SYNC_BITS*OSR consecutive clocks (48 with default parameters). A shorter high run starts no frame and produces no word.
- R2: The first low sample after a recognised sync marks offset 0 of guard bit 0. Bit k is sampled at offset k*OSR + OSR/2. Timing is counted from that falling edge, so the sync length need not be a whole number of bits.
- R3: Data bits arrive most significant first. The first data bit (third sample of the frame) lands in data_out[3] and the last in data_out[0].
- R4: Exactly eight samples (2 guard, 4 data, 2 guard) are taken per frame. The ninth timing event, at offset 8*OSR + OSR/2, ends the frame. No samples are taken after it or while the sync field is being recognised.
- R5: data_out changes only on the ninth event, and only when all four guard samples are low. Otherwise it holds its value.
- R6: word_valid is high for exactly one clock, in the same cycle as each data_out update.
- R7: A frame with any guard sample high causes no update and no word_valid pulse.
- R8: locked rises together with the first word_valid after reset or after a loss of lock.
- R9: locked falls LOCK_FRAMES*FRAME_BITS*OSR+1 clocks after the last sync end (257 with defaults) when no new sync end occurs in between.
- R10: During and right after reset, data_out is zero and word_valid and locked are low.
- R11: If a sync field is recognised before a frame's ninth event, that frame is abandoned without an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OSR periods per bit |
| rst | input | 1 | Synchronous active-high reset |
| pcm_in | input | 1 | Serial PCM line |
| data_out | output | DATA_W | Last accepted data word, held |
| word_valid | output | 1 | One-clock pulse on each word update |
| locked | output | 1 | Frames are arriving within the lock window |

## Verification
The ninth timing event of a frame falls inside the next sync field, so the word transfer and the run count for the following sync always overlap. The bench drives back-to-back frames, including sync fields that are not a whole number of bits long. A frame can also be cut short: its data ones run straight into the sync field, so sync recognition competes with the pending samples. The per-clock model requires that the cut frame is dropped, and that the frame after it decodes normally.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  typedef struct packed {
    logic lead_clear;
    logic tail_clear;
  } guard_chk_t;

  function automatic int frame_slots(input int lead, input int data, input int tail);
    return lead + data + tail;
  endfunction

endpackage

// File: rtl/pcm_sync_det.sv
module pcm_sync_det #(
  parameter int OSR       = 8,
  parameter int SYNC_BITS = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic line,
  output logic sync_active,
  output logic sync_end
);
  localparam int SYNC_CLKS = SYNC_BITS * OSR;
  localparam int RW = $clog2(SYNC_CLKS + 1);
  localparam logic [RW-1:0] RMAX = RW'(SYNC_CLKS);

  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
    end else if (!line) begin
      run_cnt <= '0;
    end else if (run_cnt != RMAX) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign sync_active = (run_cnt == RMAX);
  assign sync_end    = sync_active && !line;
endmodule

// File: rtl/pcm_bit_timer.sv
module pcm_bit_timer #(
  parameter int OSR   = 8,
  parameter int SLOTS = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sync_active,
  input  logic                         sync_end,
  output logic                         sample_stb,
  output logic                         latch_stb,
  output logic [$clog2(SLOTS+1)-1:0]   bit_cnt
);
  localparam int HALF = OSR / 2;
  localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW   = $clog2(SLOTS + 1);
  localparam logic [HW-1:0] HMAX  = HW'(HALF - 1);
  localparam logic [HW-1:0] HONE  = HW'(1);
  localparam logic [BW-1:0] BLAST = BW'(SLOTS);

  logic          armed;
  logic [HW-1:0] hcnt;
  logic          half_tog;
  logic          tick;

  assign tick       = armed && !sync_active && (hcnt == '0) && half_tog;
  assign sample_stb = tick && (bit_cnt != BLAST);
  assign latch_stb  = tick && (bit_cnt == BLAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      hcnt     <= '0;
      half_tog <= 1'b0;
      bit_cnt  <= '0;
    end else if (sync_end) begin
      armed    <= 1'b1;
      hcnt     <= HONE;
      half_tog <= 1'b0;
      bit_cnt  <= '0;
    end else if (sync_active) begin
      armed    <= 1'b0;
    end else if (armed) begin
      if (hcnt == HMAX) begin
        hcnt     <= '0;
        half_tog <= ~half_tog;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
      if (sample_stb) bit_cnt <= bit_cnt + 1'b1;
      if (latch_stb)  armed   <= 1'b0;
    end
  end
endmodule

// File: rtl/pcm_word_shift.sv
module pcm_word_shift
  import pcm_rx_pkg::*;
#(
  parameter int DATA_W     = 4,
  parameter int LEAD_GUARD = 2,
  parameter int TAIL_GUARD = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line,
  input  logic              sample_stb,
  input  logic              latch_stb,
  output logic [DATA_W-1:0] data_out,
  output logic              word_valid
);
  localparam int SLOTS = frame_slots(LEAD_GUARD, DATA_W, TAIL_GUARD);

  logic [SLOTS-1:0] sreg;
  guard_chk_t       gchk;

  always_comb begin
    gchk.lead_clear = (sreg[SLOTS-1 -: LEAD_GUARD] == '0);
    gchk.tail_clear = (sreg[TAIL_GUARD-1:0] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
    end else if (sample_stb) begin
      sreg <= {sreg[SLOTS-2:0], line};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (latch_stb && gchk.lead_clear && gchk.tail_clear) begin
        data_out   <= sreg[TAIL_GUARD +: DATA_W];
        word_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_frame_rx.sv
module pcm_frame_rx
  import pcm_rx_pkg::*;
#(
  parameter int OSR         = 8,
  parameter int DATA_W      = 4,
  parameter int LEAD_GUARD  = 2,
  parameter int TAIL_GUARD  = 2,
  parameter int SYNC_BITS   = 6,
  parameter int SYNC_FIELD  = 8,
  parameter int LOCK_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pcm_in,
  output logic [DATA_W-1:0] data_out,
  output logic              word_valid,
  output logic              locked
);
  localparam int SLOTS      = frame_slots(LEAD_GUARD, DATA_W, TAIL_GUARD);
  localparam int FRAME_BITS = SLOTS + SYNC_FIELD;
  localparam int LIM        = LOCK_FRAMES * FRAME_BITS * OSR;
  localparam int WW         = $clog2(LIM + 1);
  localparam int BW         = $clog2(SLOTS + 1);
  localparam logic [WW-1:0] WMAX = WW'(LIM);

  logic          in_q;
  logic          sync_active;
  logic          sync_end;
  logic          sample_stb;
  logic          latch_stb;
  logic [BW-1:0] bit_cnt;
  logic [WW-1:0] wd_cnt;

  always_ff @(posedge clk) begin
    if (rst) in_q <= 1'b0;
    else     in_q <= pcm_in;
  end

  pcm_sync_det #(.OSR(OSR), .SYNC_BITS(SYNC_BITS)) u_sync (
    .clk(clk), .rst(rst), .line(in_q),
    .sync_active(sync_active), .sync_end(sync_end)
  );

  pcm_bit_timer #(.OSR(OSR), .SLOTS(SLOTS)) u_timer (
    .clk(clk), .rst(rst),
    .sync_active(sync_active), .sync_end(sync_end),
    .sample_stb(sample_stb), .latch_stb(latch_stb), .bit_cnt(bit_cnt)
  );

  pcm_word_shift #(.DATA_W(DATA_W), .LEAD_GUARD(LEAD_GUARD), .TAIL_GUARD(TAIL_GUARD)) u_shift (
    .clk(clk), .rst(rst), .line(in_q),
    .sample_stb(sample_stb), .latch_stb(latch_stb),
    .data_out(data_out), .word_valid(word_valid)
  );

  // lock window: counts clocks since the last sync end
  always_ff @(posedge clk) begin
    if (rst) begin
      wd_cnt <= WMAX;
      locked <= 1'b0;
    end else begin
      if (sync_end)            wd_cnt <= '0;
      else if (wd_cnt != WMAX) wd_cnt <= wd_cnt + 1'b1;
      if (word_valid_next())   locked <= 1'b1;
      else if (!sync_end && wd_cnt == WMAX) locked <= 1'b0;
    end
  end

  function automatic logic word_valid_next();
    return latch_stb && (u_shift.gchk.lead_clear && u_shift.gchk.tail_clear);
  endfunction
endmodule

// File: rtl/pcm_frame_rx_chk.sv
module pcm_frame_rx_chk #(
  parameter int DATA_W = 4,
  parameter int BW     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] data_out,
  input logic              word_valid,
  input logic              locked,
  input logic              sync_active,
  input logic              sample_stb,
  input logic              latch_stb,
  input logic [BW-1:0]     bit_cnt
);
  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !word_valid |-> $stable(data_out));

  // R5
  update_after_ninth_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> $past(latch_stb));

  // R8
  lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> word_valid);

  // R4
  sync_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
    sync_active |-> !(sample_stb || latch_stb));

  // R4
  ninth_after_eight_chk: assert property (@(posedge clk) disable iff (rst)
    latch_stb |=> (bit_cnt == $past(bit_cnt)));
endmodule

bind pcm_frame_rx pcm_frame_rx_chk #(.DATA_W(DATA_W), .BW(BW)) u_chk (
  .clk(clk), .rst(rst), .data_out(data_out), .word_valid(word_valid),
  .locked(locked), .sync_active(sync_active), .sample_stb(sample_stb),
  .latch_stb(latch_stb), .bit_cnt(bit_cnt)
);

// File: tb/pcm_frame_rx_test.sv
module pcm_frame_rx_test;
  localparam int OSR       = 8;
  localparam int HALF      = OSR / 2;
  localparam int SYNC_CLKS = 6 * OSR;
  localparam int LIM       = 2 * 16 * OSR;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pcm_in = 1'b0;
  logic [3:0] data_out;
  logic       word_valid;
  logic       locked;

  int checks = 0;
  int errs   = 0;
  int vcount = 0;
  int cyc    = 0;
  bit started = 0;

  always #10 clk = ~clk;

  pcm_frame_rx uut (
    .clk(clk), .rst(rst), .pcm_in(pcm_in),
    .data_out(data_out), .word_valid(word_valid), .locked(locked)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference: run length, clocks since sync end, sample queue
  int        m_run, m_t, m_wd;
  bit        m_inq;
  bit        q[$];
  logic [3:0] e_data;
  bit        e_valid, e_lock;

  always @(posedge clk) begin : model
    bit sact, send, done;
    int k;
    cyc++;
    if (rst) begin
      m_run = 0; m_t = 0; m_wd = LIM; m_inq = 0;
      e_data = 0; e_valid = 0; e_lock = 0; q.delete();
    end else begin
      sact = (m_run >= SYNC_CLKS);
      send = sact && !m_inq;
      done = 0;
      e_valid = 0;
      if (!sact && m_t >= 1 && (m_t % OSR) == HALF) begin
        k = m_t / OSR;
        if (k < 8) q.push_back(m_inq);
        else begin
          done = 1;
          if (!q[0] && !q[1] && !q[6] && !q[7]) begin
            e_data = {q[2], q[3], q[4], q[5]};
            e_valid = 1;
            e_lock = 1;
          end
        end
      end
      if (send) begin m_t = 1; q.delete(); end
      else if (sact || done) m_t = 0;
      else if (m_t >= 1) m_t++;
      if (!e_valid && !send && m_wd == LIM) e_lock = 0;
      if (send) m_wd = 0;
      else if (m_wd < LIM) m_wd++;
      m_run = m_inq ? ((m_run < SYNC_CLKS) ? m_run + 1 : m_run) : 0;
      m_inq = pcm_in;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      check(data_out == e_data, "R5 data_out", data_out, e_data);
      check(word_valid == e_valid, "R6 word_valid", word_valid, e_valid);
      check(locked == e_lock, "R8/R9 locked", locked, e_lock);
      if (word_valid) vcount++;
    end
  end

  task automatic send_bit(input bit b);
    pcm_in = b;
    repeat (OSR) @(negedge clk);
  endtask

  task automatic send_high(input int clks);
    pcm_in = 1'b1;
    repeat (clks) @(negedge clk);
  endtask

  task automatic send_frame(input bit [1:0] lead, input bit [3:0] d, input bit [1:0] tail);
    for (int i = 1; i >= 0; i--) send_bit(lead[i]);
    for (int i = 3; i >= 0; i--) send_bit(d[i]);
    for (int i = 1; i >= 0; i--) send_bit(tail[i]);
  endtask

  initial begin
    repeat (2000000) @(negedge clk);
    errs++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10
    check(data_out == 0, "R10 data_out", data_out, 0);
    check(word_valid == 0, "R10 word_valid", word_valid, 0);
    check(locked == 0, "R10 locked", locked, 0);
    rst = 1'b0;
    started = 1;
    repeat (20) send_bit(1'b0);

    // R1: five-bit high run is not a sync
    repeat (5) send_bit(1'b1);
    repeat (20) send_bit(1'b0);
    check(vcount == 0, "R1 no word", vcount, 0);
    check(locked == 0, "R1 no lock", locked, 0);

    send_high(64);
    send_frame(2'b00, 4'hA, 2'b00);
    send_high(64);
    check(data_out == 4'hA, "R4 word A", data_out, 4'hA);
    check(vcount == 1, "R4 one word per frame", vcount, 1);
    check(locked == 1, "R8 lock", locked, 1);

    send_frame(2'b00, 4'h5, 2'b00);
    send_high(67);  // R2: sync not a whole number of bits
    check(data_out == 4'h5, "R2 word 5", data_out, 4'h5);

    send_frame(2'b00, 4'hF, 2'b00);
    send_high(64);
    check(data_out == 4'hF, "R4 word F", data_out, 4'hF);
    check(vcount == 3, "R4 count", vcount, 3);

    send_frame(2'b00, 4'h9, 2'b00);
    send_high(80);
    check(data_out[3] == 1'b1, "R3 msb first", data_out[3], 1);
    check(data_out == 4'h9, "R3 word 9", data_out, 4'h9);

    // R7: bad guards
    send_frame(2'b10, 4'h3, 2'b00);
    send_high(64);
    check(data_out == 4'h9, "R7 lead guard hold", data_out, 4'h9);
    send_frame(2'b00, 4'h3, 2'b01);
    send_high(64);
    check(data_out == 4'h9, "R7 tail guard hold", data_out, 4'h9);
    check(vcount == 4, "R7 no pulse", vcount, 4);

    // R11: data ones run into sync before the ninth event
    send_bit(1'b0); send_bit(1'b0);
    repeat (4) send_bit(1'b1);
    send_high(64);
    check(data_out == 4'h9, "R11 abandoned", data_out, 4'h9);
    check(vcount == 4, "R11 no pulse", vcount, 4);

    send_frame(2'b00, 4'h6, 2'b00);
    send_high(64);
    check(data_out == 4'h6, "R11 recovery", data_out, 4'h6);

    // R9: silence; an all-low frame decodes as zero, then lock times out
    pcm_in = 1'b0;
    repeat (100) @(negedge clk);
    check(data_out == 4'h0, "R5 zero frame", data_out, 0);
    check(locked == 1, "R9 still locked", locked, 1);
    repeat (LIM) @(negedge clk);
    check(locked == 0, "R9 lock lost", locked, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule